// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block collects interrupt requests from up to eight peripheral lines and presents at most one of them at a time to a processor. A request is captured on the rising edge of its line and stays pending until the processor takes it. Each line has a mask bit. A priority resolver compares the best unmasked pending line against every level that is already being serviced, so a routine can be interrupted only by something more urgent. When the resolver finds such a line, the active-high interrupt output rises.

The processor answers by pulling the active-low acknowledge low. The controller then moves the winning line from pending to in-service and drives a vector byte on the data bus. The upper bits of that byte are a programmable base and the low three bits are the line number. A routine finishes only when software writes an end-of-interrupt command, either for the most urgent level in service or for a named level. Software can choose a fixed order or a rotating order. In the rotating order, a line that has just been serviced drops to the back of the queue.

Host access uses an active-low select, read strobe and write strobe, plus one address bit. The mask register is at address 0. The in-service register reads back at address 1, and commands are written there. Each write strobe acts once, however long it is held.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the interrupt output is low, the mask and in-service registers read 0, the order is fixed and the vector base is 0.
- R2: A request is latched on a rising edge of its line and stays pending after the line falls, until it is acknowledged.
- R3: The mask register is written and read at address 0. A set mask bit keeps its line from raising the interrupt, but a request on that line stays pending and raises the interrupt once the bit is cleared.
- R4: In fixed order, line 0 is the most urgent and line 7 the least.
- R5: The interrupt output is high only while some unmasked pending line is strictly more urgent than every level in service.
- R6: A falling edge of the acknowledge while the interrupt is high moves the winning line into service and clears it from pending. While the acknowledge stays low, the data bus carries base·8 + line number.
- R7: An acknowledge while the interrupt is low changes no state, and the vector reads base·8 + 7.
- R8: The command 0x00 (bits 7:6 = 00) clears the most urgent in-service bit.
- R9: A command with bits 7:6 = 01 clears the in-service bit named by bits 2:0.
- R10: A command with bits 7:6 = 10 sets the order: bit 0 = 1 selects rotating, 0 selects fixed and restores line 0 as most urgent. In rotating order, the line cleared by command 0x00 becomes the least urgent.
- R11: A command with bits 7:6 = 11 loads bits 4:0 as the upper five bits of the vector.
- R12: With select and read low, address 0 reads the mask and address 1 reads the in-service register. While the acknowledge is low, the vector takes the bus instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Host select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| addr | input | 1 | 0 = mask register, 1 = in-service / command |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data or interrupt vector |
| irq_lines | input | 8 | Request lines, line 0 to line 7 |
| int_out | output | 1 | Interrupt to the processor, active high |
| inta_n | input | 1 | Acknowledge from the processor, active low |

## Verification
Single requests, simultaneous pairs and requests that arrive while a routine is in service are each acknowledged. Comparing the returned vector against the expected line separates correct ordering from a reversed or rotated order and from broken nesting. Rotating order is driven through several end-of-interrupt cycles. Each pair is chosen so that only a correctly moved least-urgent pointer picks the expected line. A masked request is followed by unmasking, which separates a dropped request from a held one. An acknowledge with nothing eligible, and specific clearing while a lower line waits, cover the spurious vector and the selective clearing paths.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    parameter int IRQ_N  = 8;
    parameter int ID_W   = $clog2(IRQ_N);
    parameter int DATA_W = 8;
    parameter int BASE_W = DATA_W - ID_W;
    parameter int ARG_W  = DATA_W - 2;

    typedef logic [IRQ_N-1:0]  lines_t;
    typedef logic [ID_W-1:0]   id_t;
    typedef logic [BASE_W-1:0] base_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic hit;
        id_t  id;
    } pick_t;

    typedef enum logic [1:0] {
        OP_EOI_ANY = 2'b00,
        OP_EOI_ONE = 2'b01,
        OP_MODE    = 2'b10,
        OP_BASE    = 2'b11
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [ARG_W-1:0] arg;
    } cmd_t;

    // first set bit found when scanning upward from start, wrapping
    function automatic pick_t pick_first(lines_t v, id_t start);
        pick_t r;
        id_t   idx;
        r = '0;
        for (int k = IRQ_N - 1; k >= 0; k--) begin
            idx = start + id_t'(k);
            if (v[idx]) begin
                r.hit = 1'b1;
                r.id  = idx;
            end
        end
        return r;
    endfunction

    // distance from the most urgent slot; 0 = most urgent
    function automatic id_t urgency(id_t id, id_t start);
        return id - start;
    endfunction

endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch
    import irq_prio_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  lines_t lines_in,
    input  lines_t take,
    output lines_t pending
);
    lines_t prev_q;
    lines_t pend_q;
    lines_t rise;

    assign rise = lines_in & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= lines_in;
            pend_q <= (pend_q | rise) & ~take;
        end
    end

    assign pending = pend_q;
endmodule

// File: rtl/irq_host_regs.sv
module irq_host_regs
    import irq_prio_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cs_n,
    input  logic   wr_n,
    input  logic   addr,
    input  byte_t  din,
    input  pick_t  top_srv,
    output lines_t mask,
    output base_t  base,
    output id_t    last_id,
    output lines_t eoi_clr
);
    logic   wr_act, wr_act_q, wr_go;
    logic   rot_q;
    lines_t mask_q;
    base_t  base_q;
    id_t    last_q;
    cmd_t   cmd;

    assign wr_act = !cs_n && !wr_n;
    assign wr_go  = wr_act && !wr_act_q;
    assign cmd    = cmd_t'(din);

    always_comb begin
        eoi_clr = '0;
        if (wr_go && addr) begin
            case (cmd.op)
                OP_EOI_ANY: if (top_srv.hit) eoi_clr[top_srv.id] = 1'b1;
                OP_EOI_ONE: eoi_clr[cmd.arg[ID_W-1:0]] = 1'b1;
                default:    eoi_clr = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_act_q <= 1'b0;
            rot_q    <= 1'b0;
            mask_q   <= '0;
            base_q   <= '0;
            last_q   <= '1;
        end else begin
            wr_act_q <= wr_act;
            if (wr_go && !addr) begin
                mask_q <= lines_t'(din);
            end else if (wr_go && addr) begin
                case (cmd.op)
                    OP_MODE: begin
                        rot_q  <= cmd.arg[0];
                        last_q <= '1;
                    end
                    OP_BASE: base_q <= cmd.arg[BASE_W-1:0];
                    OP_EOI_ANY: if (rot_q && top_srv.hit) last_q <= top_srv.id;
                    default: ;
                endcase
            end
        end
    end

    assign mask    = mask_q;
    assign base    = base_q;
    assign last_id = last_q;
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irq_prio_pkg::*;
(
    input  lines_t pending,
    input  lines_t mask,
    input  lines_t in_srv,
    input  id_t    last_id,
    output pick_t  win,
    output pick_t  top_srv,
    output logic   grant
);
    id_t start;

    assign start   = last_id + id_t'(1);
    assign win     = pick_first(pending & ~mask, start);
    assign top_srv = pick_first(in_srv, start);
    assign grant   = win.hit &&
                     (!top_srv.hit || (urgency(win.id, start) < urgency(top_srv.id, start)));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic       addr,
    input  logic [7:0] din,
    output logic [7:0] dout,
    input  logic [7:0] irq_lines,
    output logic       int_out,
    input  logic       inta_n
);
    lines_t irr_q, imr_q, isr_q, take, eoi_clr, set_srv;
    base_t  base;
    id_t    last_id;
    pick_t  win, top_srv;
    logic   grant, inta_q, ack_go;
    byte_t  vec_q;

    irq_req_latch u_latch (
        .clk(clk), .rst(rst), .lines_in(irq_lines), .take(take), .pending(irr_q)
    );

    irq_host_regs u_regs (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .addr(addr), .din(din),
        .top_srv(top_srv), .mask(imr_q), .base(base), .last_id(last_id),
        .eoi_clr(eoi_clr)
    );

    irq_prio_resolver u_res (
        .pending(irr_q), .mask(imr_q), .in_srv(isr_q), .last_id(last_id),
        .win(win), .top_srv(top_srv), .grant(grant)
    );

    assign ack_go = !inta_n && inta_q;

    always_comb begin
        set_srv = '0;
        if (ack_go && grant) set_srv[win.id] = 1'b1;
    end
    assign take = set_srv;

    always_ff @(posedge clk) begin
        if (rst) begin
            inta_q <= 1'b1;
            isr_q  <= '0;
            vec_q  <= '0;
        end else begin
            inta_q <= inta_n;
            isr_q  <= (isr_q & ~eoi_clr) | set_srv;
            if (ack_go) vec_q <= grant ? {base, win.id} : {base, {ID_W{1'b1}}};
        end
    end

    assign int_out = grant;

    always_comb begin
        if (!inta_n)               dout = vec_q;
        else if (!cs_n && !rd_n)   dout = addr ? byte_t'(isr_q) : byte_t'(imr_q);
        else                       dout = '0;
    end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
    import irq_prio_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   cs_n,
    input logic   wr_n,
    input logic   addr,
    input logic   inta_n,
    input logic   int_out,
    input byte_t  dout,
    input lines_t irr,
    input lines_t imr,
    input lines_t isr
);
    // R5: interrupt needs an eligible pending line
    assert_int_needs_pending_R5: assert property (@(posedge clk) disable iff (rst)
        int_out |-> (|(irr & ~imr)));

    // R6: at most one line enters service per cycle
    assert_one_new_srv_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(isr & ~$past(isr)));

    // R6: lines enter service only on an acknowledge edge
    assert_srv_on_ack_R6: assert property (@(posedge clk) disable iff (rst)
        (|(isr & ~$past(isr))) |-> $past($fell(inta_n)));

    // R8: service bits clear only through a command write
    assert_clear_by_cmd_R8: assert property (@(posedge clk) disable iff (rst)
        (|($past(isr) & ~isr)) |-> $past(!cs_n && !wr_n && addr));

    // R6: the vector names the line just put in service
    assert_vec_matches_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(inta_n) && int_out) |=> (inta_n || isr[dout[ID_W-1:0]]));
endmodule

bind irq_prio_ctrl irq_prio_chk u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
    .inta_n(inta_n), .int_out(int_out), .dout(dout),
    .irr(irr_q), .imr(imr_q), .isr(isr_q)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, addr = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic [7:0] irq_lines = '0;
    logic       int_out;
    logic       inta_n = 1'b1;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [7:0] v;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .irq_lines(irq_lines),
        .int_out(int_out), .inta_n(inta_n)
    );

    always #10 clk = ~clk;

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic rd(logic a, output logic [7:0] v);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1 v = dout;
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic pulse(logic [7:0] l);
        @(negedge clk);
        irq_lines = irq_lines | l;
        @(negedge clk);
        irq_lines = irq_lines & ~l;
    endtask

    // driver: pushes expected vector, then acknowledges
    task automatic ack(logic [7:0] e, string tag);
        exp_t it;
        it.v = e; it.tag = tag;
        @(negedge clk);
        exp_q.push_back(it);
        inta_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        inta_n = 1'b1;
    endtask

    // monitor: compares vector while acknowledge is held
    initial begin
        forever begin
            @(negedge inta_n);
            @(negedge clk);
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R6 unexpected ack actual=%02h expected=none", dout);
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                chk(it.tag, dout, it.v);
            end
        end
    end

    task automatic finish_up;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_up();
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 int", {7'b0, int_out}, 8'h00);
        rd(1'b0, v); chk("R1 mask", v, 8'h00);
        rd(1'b1, v); chk("R1 isr", v, 8'h00);

        // R11 base = 0x40
        wr(1'b1, 8'hC8);
        // R2 R4 two lines together, line 2 wins
        pulse(8'h24);
        @(negedge clk);
        chk("R2 int held after line drops", {7'b0, int_out}, 8'h01);
        ack(8'h42, "R4 R6 R11 vector line2");
        rd(1'b1, v); chk("R6 R12 isr", v, 8'h04);
        chk("R5 lower line blocked", {7'b0, int_out}, 8'h00);
        // R5 nesting: line 0 preempts
        pulse(8'h01);
        chk("R5 higher line preempts", {7'b0, int_out}, 8'h01);
        ack(8'h40, "R5 vector line0");
        rd(1'b1, v); chk("R5 nested isr", v, 8'h05);
        // R8 non-specific clears most urgent
        wr(1'b1, 8'h00);
        rd(1'b1, v); chk("R8 clears line0", v, 8'h04);
        chk("R5 still blocked", {7'b0, int_out}, 8'h00);
        wr(1'b1, 8'h00);
        chk("R8 line5 now eligible", {7'b0, int_out}, 8'h01);
        ack(8'h45, "R4 vector line5");
        wr(1'b1, 8'h00);

        // R3 masking
        wr(1'b0, 8'h08);
        rd(1'b0, v); chk("R3 R12 mask readback", v, 8'h08);
        pulse(8'h08);
        chk("R3 masked no int", {7'b0, int_out}, 8'h00);
        wr(1'b0, 8'h00);
        chk("R3 held after unmask", {7'b0, int_out}, 8'h01);
        ack(8'h43, "R3 vector line3");
        wr(1'b1, 8'h00);

        // R7 spurious ack
        ack(8'h47, "R7 spurious vector");
        rd(1'b1, v); chk("R7 isr unchanged", v, 8'h00);

        // R9 specific EOI
        pulse(8'h42);
        ack(8'h41, "R9 vector line1");
        ack(8'h47, "R7 blocked ack spurious");
        rd(1'b1, v); chk("R7 isr after blocked ack", v, 8'h02);
        wr(1'b1, 8'h41);
        rd(1'b1, v); chk("R9 specific clear", v, 8'h00);
        ack(8'h46, "R9 vector line6");
        wr(1'b1, 8'h46);
        rd(1'b1, v); chk("R9 specific clear line6", v, 8'h00);

        // R10 rotating order
        wr(1'b1, 8'h81);
        pulse(8'h48);
        ack(8'h43, "R10 first line3");
        wr(1'b1, 8'h00);
        pulse(8'h02);
        ack(8'h46, "R10 line6 before line1");
        wr(1'b1, 8'h00);
        ack(8'h41, "R10 line1");
        wr(1'b1, 8'h00);
        pulse(8'h05);
        ack(8'h42, "R10 line2 before line0");
        chk("R10 R5 line0 blocked", {7'b0, int_out}, 8'h00);
        wr(1'b1, 8'h00);
        ack(8'h40, "R10 line0");
        wr(1'b1, 8'h00);

        // R10 back to fixed order
        wr(1'b1, 8'h80);
        pulse(8'h90);
        ack(8'h44, "R10 R4 fixed line4");
        wr(1'b1, 8'h00);
        ack(8'h47, "R4 real line7");
        rd(1'b1, v); chk("R4 isr line7", v, 8'h80);
        wr(1'b1, 8'h00);
        rd(1'b1, v); chk("R8 all clear", v, 8'h00);

        repeat (3) @(negedge clk);
        chk("R6 queue drained", 8'(exp_q.size()), 8'h00);
        finish_up();
    end
endmodule